// File: doc/BRIEF.md
# Dual-Plane Page Program Sequencer

This block is the host-side engine that writes two pages of a NAND-type flash at once, one page into each of the two planes. A client pulses `start_i` with two column/row address pairs. The block checks that the first row selects plane 0 and the second row selects plane 1. It then drives the flash bus through two load phases and a final program phase, and it pulls page bytes from a byte-wide source with a valid/ready handshake. At the end it reports the outcome on a one-cycle `done_o` pulse. The result flags stay valid until the next accepted request.

The state machine moves through these states:
- `ST_IDLE` goes to `ST_A_SETUP` on a valid request, or to `ST_DONE` on a rejected one.
- The first load phase runs `ST_A_SETUP` (command 80h), then `ST_A_ADDR` (five address cycles), then `ST_A_DATA` (one page of data), then `ST_A_CONF` (command 11h). It then enters `ST_A_WAIT` and waits for ready.
- After ready, the second phase runs the same way through `ST_B_SETUP`, `ST_B_ADDR`, `ST_B_DATA` and `ST_B_CONF` (command 10h). It then enters `ST_B_WAIT`.
- Polling runs `ST_POLL_CMD` (command 70h), then `ST_POLL_RD` (one status read), then `ST_POLL_EVAL`. `ST_POLL_EVAL` returns to `ST_POLL_RD` while the ready bit is clear, and moves to `ST_DONE` once it is set.
- Either wait state, and `ST_POLL_EVAL`, also moves to `ST_DONE` when the busy timer expires.
- `ST_DONE` always returns to `ST_IDLE`.

Each bus write cycle takes two clocks: write strobe low, then write strobe high. Each status read holds the read strobe low for one clock.

Top module: `nf_dual_plane_prog`

## Requirements
- R1: A request whose first row has bit PLANE_BIT set, or whose second row has bit PLANE_BIT clear, ends with `done_o` one cycle after `start_i`, with `reject_o`=1 and `pass_o`=0, and with no bus cycle issued. While `chip_en_n_o` is high, both strobes stay high and the data output is not enabled.
- R2: The first phase writes command 80h, then five address bytes, then PAGE_BYTES data bytes, then command 11h. Commands are latched with `cmd_latch_o`=1 and `addr_latch_o`=0.
- R3: Every write cycle holds `wr_n_o` low for exactly one clock and then high for one clock. The latch strobes and `bus_o` stay unchanged across the rising edge.
- R4: The five address bytes are latched with `addr_latch_o`=1 and `cmd_latch_o`=0, in this order: column byte 0, column byte 1, row byte 0, row byte 1, row byte 2.
- R5: After command 11h, the block issues no write cycle until `dev_ready_i` is high, and not before SETTLE_CYCLES clocks have passed.
- R6: The second phase writes 80h, five address bytes from the second pair, PAGE_BYTES data bytes, then command 10h.
- R7: Once ready returns after 10h, the block writes command 70h and then repeats status reads (`rd_n_o` low) until status bit 6 reads 1.
- R8: When bit 6 is 1, `pass_o` equals the inverse of status bit 0, and `plane_chk_o` equals status bit 0. `plane_chk_o`=1 never comes with `pass_o`=1.
- R9: If a wait does not finish within BUSY_LIMIT clocks, the block ends with `timeout_o`=1 and `pass_o`=`plane_chk_o`=0, and issues no further bus cycle.
- R10: Data bytes are taken from the source only when `src_valid_i` is high. `src_ready_o` marks a byte that is written as data in the next cycle, and a stalled source stretches the phase without dropping or repeating a byte.
- R11: `cmd_latch_o` and `addr_latch_o` are never high together, and `bus_oe_o` is high whenever `wr_n_o` is low.
- R12: `done_o` is a single-cycle pulse, and `start_i` has no effect while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled in the idle state |
| col_a_i | input | 8*COL_BYTES | Column address of the plane-0 page |
| row_a_i | input | 8*ROW_BYTES | Row address of the plane-0 page |
| col_b_i | input | 8*COL_BYTES | Column address of the plane-1 page |
| row_b_i | input | 8*ROW_BYTES | Row address of the plane-1 page |
| src_data_i | input | 8 | Page data byte from the source |
| src_valid_i | input | 1 | Source byte available |
| src_ready_o | output | 1 | Source byte consumed this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Program reported success |
| plane_chk_o | output | 1 | Failure reported; a per-plane status query is needed |
| timeout_o | output | 1 | A wait exceeded BUSY_LIMIT |
| reject_o | output | 1 | Request refused for plane-bit violation |
| chip_en_n_o | output | 1 | Flash chip enable, active low |
| cmd_latch_o | output | 1 | Command latch strobe |
| addr_latch_o | output | 1 | Address latch strobe |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| bus_o | output | 8 | Flash data bus output |
| bus_oe_o | output | 1 | Flash data bus output enable |
| bus_i | input | 8 | Flash data bus input |
| dev_ready_i | input | 1 | Flash ready (high) / busy (low) |

## Verification
The following are checked on every cycle:
- the latch strobes are never both high;
- the write strobe has its low-then-high shape, and the latched values stay stable across the rising edge;
- every consumed source byte turns into a data write;
- `done_o` is a single-cycle pulse;
- the result flags are consistent with each other;
- a granted request carries correct plane bits.

Some behaviour only the bench scenarios can show. These are the exact byte order of both phases, gating on the ready line after each confirm, repeated status polling, and byte integrity under source stalls. They also cover where a timeout cuts the sequence, and that a second start in mid-operation changes nothing.

// File: rtl/nfprog_pkg.sv
package nfprog_pkg;

    typedef enum logic [1:0] {
        CYC_CMD,
        CYC_ADDR,
        CYC_DATA,
        CYC_READ
    } cyc_kind_t;

    localparam logic [7:0] OP_SETUP   = 8'h80;
    localparam logic [7:0] OP_MIDCONF = 8'h11;
    localparam logic [7:0] OP_CONF    = 8'h10;
    localparam logic [7:0] OP_STATUS  = 8'h70;

    localparam int STAT_READY_BIT = 6;
    localparam int STAT_FAIL_BIT  = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_SETUP,
        ST_A_ADDR,
        ST_A_DATA,
        ST_A_CONF,
        ST_A_WAIT,
        ST_B_SETUP,
        ST_B_ADDR,
        ST_B_DATA,
        ST_B_CONF,
        ST_B_WAIT,
        ST_POLL_CMD,
        ST_POLL_RD,
        ST_POLL_EVAL,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/nfprog_bus_cycle.sv
module nfprog_bus_cycle
    import nfprog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  cyc_kind_t  kind_i,
    input  logic [7:0] byte_i,
    output logic       free_o,
    output logic       rd_valid_o,
    output logic [7:0] rdata_o,
    output logic       cle_o,
    output logic       ale_o,
    output logic       we_n_o,
    output logic       re_n_o,
    output logic [7:0] io_o,
    output logic       io_oe_o,
    input  logic [7:0] io_i
);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

    phase_t     ph;
    cyc_kind_t  kind_q;
    logic [7:0] byte_q;
    logic [7:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            kind_q  <= CYC_CMD;
            byte_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (ph)
                PH_IDLE, PH_HIGH: begin
                    if (req_i) begin
                        ph     <= PH_LOW;
                        kind_q <= kind_i;
                        byte_q <= byte_i;
                    end else begin
                        ph <= PH_IDLE;
                    end
                end
                PH_LOW: begin
                    ph <= PH_HIGH;
                    if (kind_q == CYC_READ) rdata_q <= io_i;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        free_o     = (ph != PH_LOW);
        rd_valid_o = (ph == PH_HIGH) && (kind_q == CYC_READ);
        rdata_o    = rdata_q;
        cle_o      = (ph != PH_IDLE) && (kind_q == CYC_CMD);
        ale_o      = (ph != PH_IDLE) && (kind_q == CYC_ADDR);
        we_n_o     = !((ph == PH_LOW) && (kind_q != CYC_READ));
        re_n_o     = !((ph == PH_LOW) && (kind_q == CYC_READ));
        io_o       = byte_q;
        io_oe_o    = (ph != PH_IDLE) && (kind_q != CYC_READ);
    end

    // R3: one low clock, then a high clock with the latched values unchanged
    p_strobe_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n_o) |=> (we_n_o && $stable(cle_o) && $stable(ale_o) && $stable(io_o)));

    // R11: command and address latch strobes never overlap
    p_latch_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    // R11: bus is driven whenever the write strobe is low
    p_drive_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> io_oe_o);

endmodule

// File: rtl/nfprog_busy_timer.sv
module nfprog_busy_timer #(
    parameter int SETTLE = 4,
    parameter int LIMIT  = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic settled_o,
    output logic expired_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (cnt != CNT_W'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        settled_o = (cnt >= CNT_W'(SETTLE));
        expired_o = (cnt == CNT_W'(LIMIT));
    end

endmodule

// File: rtl/nf_dual_plane_prog.sv
module nf_dual_plane_prog
    import nfprog_pkg::*;
#(
    parameter int PAGE_BYTES    = 2112,
    parameter int COL_BYTES     = 2,
    parameter int ROW_BYTES     = 3,
    parameter int PLANE_BIT     = 6,
    parameter int SETTLE_CYCLES = 4,
    parameter int BUSY_LIMIT    = 200000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [8*COL_BYTES-1:0] col_a_i,
    input  logic [8*ROW_BYTES-1:0] row_a_i,
    input  logic [8*COL_BYTES-1:0] col_b_i,
    input  logic [8*ROW_BYTES-1:0] row_b_i,
    input  logic [7:0]             src_data_i,
    input  logic                   src_valid_i,
    output logic                   src_ready_o,
    output logic                   done_o,
    output logic                   pass_o,
    output logic                   plane_chk_o,
    output logic                   timeout_o,
    output logic                   reject_o,
    output logic                   chip_en_n_o,
    output logic                   cmd_latch_o,
    output logic                   addr_latch_o,
    output logic                   wr_n_o,
    output logic                   rd_n_o,
    output logic [7:0]             bus_o,
    output logic                   bus_oe_o,
    input  logic [7:0]             bus_i,
    input  logic                   dev_ready_i
);

    localparam int COL_W       = 8 * COL_BYTES;
    localparam int ROW_W       = 8 * ROW_BYTES;
    localparam int ADDR_CYCLES = COL_BYTES + ROW_BYTES;
    localparam int CNT_MAX     = (PAGE_BYTES > ADDR_CYCLES) ? PAGE_BYTES : ADDR_CYCLES;
    localparam int IDX_W       = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

    seq_state_t       state, nxt;
    logic [IDX_W-1:0] idx;
    logic [COL_W-1:0] col_a, col_b;
    logic [ROW_W-1:0] row_a, row_b;
    logic             pass_q, chk_q, tmo_q, rej_q;

    logic             bus_req, bus_free, rd_valid;
    cyc_kind_t        bus_kind;
    logic [7:0]       bus_byte, rdata;
    logic             tmr_run, settled, expired;
    logic             plane_ok, last_addr, last_data;

    function automatic logic [7:0] addr_byte(input logic [COL_W-1:0] c,
                                             input logic [ROW_W-1:0] r,
                                             input logic [IDX_W-1:0] i);
        logic [COL_W+ROW_W-1:0] cat;
        cat = {r, c};
        return 8'(cat >> (8 * i));
    endfunction

    nfprog_bus_cycle u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (bus_req),
        .kind_i     (bus_kind),
        .byte_i     (bus_byte),
        .free_o     (bus_free),
        .rd_valid_o (rd_valid),
        .rdata_o    (rdata),
        .cle_o      (cmd_latch_o),
        .ale_o      (addr_latch_o),
        .we_n_o     (wr_n_o),
        .re_n_o     (rd_n_o),
        .io_o       (bus_o),
        .io_oe_o    (bus_oe_o),
        .io_i       (bus_i)
    );

    nfprog_busy_timer #(
        .SETTLE (SETTLE_CYCLES),
        .LIMIT  (BUSY_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .settled_o (settled),
        .expired_o (expired)
    );

    assign plane_ok  = !row_a_i[PLANE_BIT] && row_b_i[PLANE_BIT];
    assign last_addr = (idx == IDX_W'(ADDR_CYCLES - 1));
    assign last_data = (idx == IDX_W'(PAGE_BYTES - 1));
    assign tmr_run   = (state == ST_A_WAIT) || (state == ST_B_WAIT) ||
                       (state == ST_POLL_CMD) || (state == ST_POLL_RD) ||
                       (state == ST_POLL_EVAL);

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            col_a  <= '0;
            col_b  <= '0;
            row_a  <= '0;
            row_b  <= '0;
            pass_q <= 1'b0;
            chk_q  <= 1'b0;
            tmo_q  <= 1'b0;
            rej_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (bus_req) idx <= (nxt != state) ? '0 : idx + 1'b1;
            if (state == ST_IDLE && start_i) begin
                col_a  <= col_a_i;
                row_a  <= row_a_i;
                col_b  <= col_b_i;
                row_b  <= row_b_i;
                rej_q  <= !plane_ok;
                pass_q <= 1'b0;
                chk_q  <= 1'b0;
                tmo_q  <= 1'b0;
            end else if (state == ST_POLL_EVAL && rd_valid && rdata[STAT_READY_BIT]) begin
                pass_q <= !rdata[STAT_FAIL_BIT];
                chk_q  <= rdata[STAT_FAIL_BIT];
            end else if (nxt == ST_DONE && state != ST_IDLE) begin
                tmo_q <= 1'b1;
            end
        end
    end

    // Next state and bus requests
    always_comb begin
        nxt         = state;
        bus_req     = 1'b0;
        bus_kind    = CYC_CMD;
        bus_byte    = '0;
        src_ready_o = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) nxt = plane_ok ? ST_A_SETUP : ST_DONE;
            end
            ST_A_SETUP, ST_B_SETUP: begin
                if (bus_free) begin
                    bus_req  = 1'b1;
                    bus_byte = OP_SETUP;
                    nxt      = (state == ST_A_SETUP) ? ST_A_ADDR : ST_B_ADDR;
                end
            end
            ST_A_ADDR, ST_B_ADDR: begin
                if (bus_free) begin
                    bus_req  = 1'b1;
                    bus_kind = CYC_ADDR;
                    bus_byte = (state == ST_A_ADDR) ? addr_byte(col_a, row_a, idx)
                                                    : addr_byte(col_b, row_b, idx);
                    if (last_addr) nxt = (state == ST_A_ADDR) ? ST_A_DATA : ST_B_DATA;
                end
            end
            ST_A_DATA, ST_B_DATA: begin
                if (bus_free && src_valid_i) begin
                    bus_req     = 1'b1;
                    bus_kind    = CYC_DATA;
                    bus_byte    = src_data_i;
                    src_ready_o = 1'b1;
                    if (last_data) nxt = (state == ST_A_DATA) ? ST_A_CONF : ST_B_CONF;
                end
            end
            ST_A_CONF: begin
                if (bus_free) begin
                    bus_req  = 1'b1;
                    bus_byte = OP_MIDCONF;
                    nxt      = ST_A_WAIT;
                end
            end
            ST_B_CONF: begin
                if (bus_free) begin
                    bus_req  = 1'b1;
                    bus_byte = OP_CONF;
                    nxt      = ST_B_WAIT;
                end
            end
            ST_A_WAIT: begin
                if (settled && dev_ready_i) nxt = ST_B_SETUP;
                else if (expired)           nxt = ST_DONE;
            end
            ST_B_WAIT: begin
                if (settled && dev_ready_i) nxt = ST_POLL_CMD;
                else if (expired)           nxt = ST_DONE;
            end
            ST_POLL_CMD: begin
                if (bus_free) begin
                    bus_req  = 1'b1;
                    bus_byte = OP_STATUS;
                    nxt      = ST_POLL_RD;
                end
            end
            ST_POLL_RD: begin
                if (bus_free) begin
                    bus_req  = 1'b1;
                    bus_kind = CYC_READ;
                    nxt      = ST_POLL_EVAL;
                end
            end
            ST_POLL_EVAL: begin
                if (rd_valid)     nxt = rdata[STAT_READY_BIT] ? ST_DONE : ST_POLL_RD;
                else if (expired) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done_o      = (state == ST_DONE);
        chip_en_n_o = (state == ST_IDLE) || (state == ST_DONE);
        pass_o      = pass_q;
        plane_chk_o = chk_q;
        timeout_o   = tmo_q;
        reject_o    = rej_q;
    end

    // R1: a granted request always holds correct plane bits
    p_plane_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_A_SETUP) |-> (!row_a[PLANE_BIT] && row_b[PLANE_BIT]));

    // R1: no bus strobe while the chip is deselected
    p_quiet_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n_o |-> (wr_n_o && rd_n_o && !bus_oe_o));

    // R10: every consumed byte becomes a data write in the next cycle
    p_byte_to_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready_o |=> (!wr_n_o && bus_oe_o && !cmd_latch_o && !addr_latch_o));

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a per-plane check is only requested for a failed program
    p_chk_not_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(plane_chk_o && pass_o));

    // R9: a timed-out operation reports neither pass nor a plane check
    p_timeout_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> (!pass_o && !plane_chk_o));

endmodule

// File: tb/test_nf_dual_plane_prog.sv
`timescale 1ns/1ps
module test_nf_dual_plane_prog;

    localparam int PB    = 3;
    localparam int LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] col_a = '0, col_b = '0;
    logic [23:0] row_a = '0, row_b = '0;
    logic [7:0]  src_data;
    logic        src_valid = 1'b0;
    logic        src_ready, done, pass, plane_chk, tmo, rej;
    logic        ce_n, cle, ale, we_n, re_n, oe;
    logic [7:0]  bus_out, bus_in;
    logic        rb = 1'b1;

    int checks = 0;
    int errors = 0;

    // bench models
    int   lg_n = 0, rd_cnt = 0, bad_pulse = 0, rb_viol = 0, rb_cnt = 0, we_low_run = 0;
    logic [1:0] lg_kind [0:511];
    logic [7:0] lg_byte [0:511];
    logic prev_we = 1'b1, prev_re = 1'b1, took = 1'b0;
    int   hold_a = 4, hold_b = 6, busy_reads = 0, rd0 = 0, vmode = 0, sidx = 0, cyc = 0;
    logic [7:0] fin_stat = 8'h40;

    always #2 clk = ~clk;

    assign src_data = 8'(sidx) ^ 8'h5A;
    assign bus_in   = re_n ? 8'h00 : (((rd_cnt - rd0) < busy_reads) ? 8'h00 : fin_stat);

    nf_dual_plane_prog #(
        .PAGE_BYTES    (PB),
        .SETTLE_CYCLES (3),
        .BUSY_LIMIT    (LIMIT)
    ) i_nf_dual_plane_prog (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .col_a_i(col_a), .row_a_i(row_a), .col_b_i(col_b), .row_b_i(row_b),
        .src_data_i(src_data), .src_valid_i(src_valid), .src_ready_o(src_ready),
        .done_o(done), .pass_o(pass), .plane_chk_o(plane_chk), .timeout_o(tmo), .reject_o(rej),
        .chip_en_n_o(ce_n), .cmd_latch_o(cle), .addr_latch_o(ale), .wr_n_o(we_n), .rd_n_o(re_n),
        .bus_o(bus_out), .bus_oe_o(oe), .bus_i(bus_in), .dev_ready_i(rb)
    );

    // Bus monitor and flash ready/busy model, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) we_low_run++;
            if (!prev_we && we_n) begin
                if (lg_n < 512) begin
                    lg_kind[lg_n] = {ale, cle};
                    lg_byte[lg_n] = bus_out;
                    lg_n++;
                end
                if (we_low_run != 1) bad_pulse++;
                we_low_run = 0;
                if (!rb) rb_viol++;
                if (cle && (bus_out == 8'h11 || bus_out == 8'h10)) begin
                    rb     = 1'b0;
                    rb_cnt = (bus_out == 8'h11) ? hold_a : hold_b;
                end
            end else if (!rb) begin
                if (rb_cnt == 0) rb = 1'b1;
                else rb_cnt--;
            end
            if (!prev_re && re_n) rd_cnt++;
            took    = src_ready && src_valid;
            prev_we = we_n;
            prev_re = re_n;
        end
    end

    // Byte source with programmable stall pattern
    always @(posedge clk) begin
        #1;
        cyc++;
        if (took) sidx++;
        src_valid = (vmode == 0) || ((cyc % (vmode + 1)) != 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // outcome: 0 pass, 1 fail, 2 reject, 3 timeout phase A, 4 timeout phase B
    task automatic run_op(input int outcome, input int k, input bit restart, input int settle_wait);
        int lg0, s0, bp0, rv0, exp_n, got_n;
        bit seen;
        logic [1:0] ek [0:31];
        logic [7:0] eb [0:31];
        int n;
        @(negedge clk);
        lg0 = lg_n; s0 = sidx; bp0 = bad_pulse; rv0 = rb_viol; rd0 = rd_cnt;
        col_a = 16'h0A10 + 16'(k * 16'h0101);
        col_b = 16'h0B20 + 16'(k * 16'h0111);
        row_a = 24'h123480 + 24'(k << 8);
        row_b = 24'h4567C1 + 24'(k << 12);
        if (outcome == 2 && k[0]) row_a[6] = 1'b1;
        if (outcome == 2 && !k[0]) row_b[6] = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (6) @(negedge clk);
            row_a[6] = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            row_a[6] = 1'b0;
        end
        seen = 0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        check(seen, "R12", "done seen", seen, 1);
        check(rej == (outcome == 2), "R1", "reject flag", rej, outcome == 2);
        check(tmo == (outcome >= 3), "R9", "timeout flag", tmo, outcome >= 3);
        check(pass == (outcome == 0), "R8", "pass flag", pass, outcome == 0);
        check(plane_chk == (outcome == 1), "R8", "plane check flag", plane_chk, outcome == 1);
        @(negedge clk);
        check(!done, "R12", "done single pulse", done, 0);
        repeat (settle_wait) @(negedge clk);

        // expected write sequence: kind {addr,cmd}
        n = 0;
        ek[n] = 2'b01; eb[n] = 8'h80; n++;
        for (int j = 0; j < 2; j++) begin ek[n] = 2'b10; eb[n] = 8'(col_a >> (8*j)); n++; end
        for (int j = 0; j < 3; j++) begin ek[n] = 2'b10; eb[n] = 8'(row_a >> (8*j)); n++; end
        for (int j = 0; j < PB; j++) begin ek[n] = 2'b00; eb[n] = 8'(s0 + j) ^ 8'h5A; n++; end
        ek[n] = 2'b01; eb[n] = 8'h11; n++;
        ek[n] = 2'b01; eb[n] = 8'h80; n++;
        for (int j = 0; j < 2; j++) begin ek[n] = 2'b10; eb[n] = 8'(col_b >> (8*j)); n++; end
        for (int j = 0; j < 3; j++) begin ek[n] = 2'b10; eb[n] = 8'(row_b >> (8*j)); n++; end
        for (int j = 0; j < PB; j++) begin ek[n] = 2'b00; eb[n] = 8'(s0 + PB + j) ^ 8'h5A; n++; end
        ek[n] = 2'b01; eb[n] = 8'h10; n++;
        ek[n] = 2'b01; eb[n] = 8'h70; n++;

        exp_n = (outcome == 2) ? 0 : (outcome == 3) ? (PB + 7) : (outcome == 4) ? (2*PB + 14) : n;
        got_n = lg_n - lg0;
        check(got_n == exp_n, (outcome >= 3) ? "R9" : "R2", "write cycle count", got_n, exp_n);
        for (int j = 0; j < exp_n && j < got_n; j++) begin
            string tg;
            tg = (ek[j] == 2'b10) ? "R4" : (ek[j] == 2'b00) ? "R10" : (j < PB + 7) ? "R2" : "R6";
            check(lg_kind[lg0 + j] == ek[j], tg, "cycle kind", lg_kind[lg0 + j], ek[j]);
            check(lg_byte[lg0 + j] == eb[j], tg, "cycle byte", lg_byte[lg0 + j], eb[j]);
        end
        check((rd_cnt - rd0) == ((outcome <= 1) ? busy_reads + 1 : 0), "R7", "status reads",
              rd_cnt - rd0, (outcome <= 1) ? busy_reads + 1 : 0);
        check(bad_pulse == bp0, "R3", "write strobe shape", bad_pulse - bp0, 0);
        check(rb_viol == rv0, "R5", "write while busy", rb_viol - rv0, 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R11, R12)
        check(!done, "R12", "reset done", done, 0);
        check(ce_n && we_n && re_n, "R1", "reset strobes", {ce_n, we_n, re_n}, 3'b111);
        check(!cle && !ale && !oe, "R11", "reset latches", {cle, ale, oe}, 0);
        check(!src_ready, "R10", "reset src_ready", src_ready, 0);

        // R1: plane violations in either address
        run_op(2, 1, 0, 2);
        run_op(2, 2, 0, 2);

        // sweep: stall pattern x status outcome, increasing busy polls
        for (int vm = 0; vm < 3; vm++) begin
            for (int oc = 0; oc < 2; oc++) begin
                vmode      = vm;
                busy_reads = vm;
                hold_a     = 2 + vm;
                hold_b     = 5 + 2 * vm;
                fin_stat   = (oc == 1) ? 8'h41 : 8'h40;
                run_op(oc, vm * 2 + oc, (vm == 1 && oc == 0), 4);
            end
        end

        // R9: ready never returns in either phase
        vmode = 0; busy_reads = 0; fin_stat = 8'h40;
        hold_a = 60; hold_b = 6;
        run_op(3, 7, 0, 70);
        hold_a = 3; hold_b = 60;
        run_op(4, 8, 0, 70);

        // normal operation still works after timeouts
        hold_b = 6;
        run_op(0, 9, 0, 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule